// File: doc/BRIEF.md
# Program Status Polling Read Path

This block is the read multiplexer in front of a sector-programmed flash array. When no program period is running, a read returns the array word at the current address, or an identification byte when the command decoder asks for one. While the program period runs (the `busy` input is high), the array is not readable. A read then returns a status byte instead, and software uses it to find the end of the cycle. The top bit is the inverse of the top bit of the last loaded byte. The next bit alternates on every new read access. All lower bits read as zero.

A read access exists only while chip select and output enable are both low and write enable is high. The block registers all of its outputs, so a result appears one clock after the inputs that produce it. A new access is the first cycle in which the access condition is true after a cycle in which it was false. Software can therefore start a fresh access by releasing chip select, output enable, or both. The `busy` input may come from a real program cycle or from a rejected write under software protection; this block treats the two cases the same. Array timing and pad drive are handled elsewhere.

Top module: `poll_read_path`

## Requirements
- R1: During reset and in the first cycle after it, `rd_valid` is 0 and `rd_data` is all zeros. The toggle bit resets to 0.
- R2: If `cs_n` is high, `oe_n` is high or `we_n` is low in a cycle, the next cycle shows `rd_valid` = 0 and `rd_data` = 0.
- R3: An access with `busy` low and `id_sel` low returns `rd_valid` = 1 and `rd_data` equal to `array_data` from the previous cycle.
- R4: An access with `busy` low and `id_sel` high returns `id_data` from the previous cycle. `array_data` has no effect on the result.
- R5: An access with `busy` high returns bit 7 equal to the inverse of bit 7 of `last_byte` from the previous cycle.
- R6: An access with `busy` high returns bits 5 down to 0 as zero, whatever the array and identification inputs hold.
- R7: With `busy` high, bit 6 inverts at the first cycle of each new access and holds its value for as long as that access lasts.
- R8: Once `busy` falls, accesses return true data on all bits. Further accesses with `busy` low leave the toggle state unchanged.
- R9: Polling may begin at any point. An access that is already running when `busy` rises returns status from the next cycle onward, and that access does not invert bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Program period active |
| last_byte | input | DATA_W | Last byte loaded for programming |
| array_data | input | DATA_W | Array word at the current address |
| id_sel | input | 1 | Identification override request |
| id_data | input | DATA_W | Identification byte |
| rd_valid | output | 1 | Registered read-access indicator |
| rd_data | output | DATA_W | Registered read data |

## Verification
The assertions assume that `busy`, `last_byte`, `array_data` and the identification inputs are synchronous to `clk` and hold steady for one cycle at a time. The bench drives every input at the falling edge, so each value is settled well before the rising edge that samples it. Bit 6 is checked for stability only when one access and a high `busy` both span consecutive cycles after reset, because the state at reset exit is a defined zero. The stimulus releases and re-asserts the select lines between accesses, which gives clean new-access edges. It also holds a single access across a rising `busy` to cover the R9 case.

// File: rtl/poll_pkg.sv
// Shared types for the polling read path.
// Assumes: one data byte per access; the status bits sit at the top of the word.
package poll_pkg;
    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_IDENT  = 2'd2,
        SRC_STATUS = 2'd3
    } rd_src_e;
endpackage

// File: rtl/pr_select_edge.sv
// Decodes the read-access condition and flags the first cycle of each access.
// Assumes: the strobes are already synchronous to clk.
module pr_select_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic oe_n,
    input  logic we_n,
    output logic access,
    output logic access_start
);
    logic access_q;

    // Access condition: both selects low and no write in progress.
    always_comb access = !cs_n && !oe_n && we_n;

    // Remember the previous cycle's access condition.
    always_ff @(posedge clk) begin
        if (!rst_n) access_q <= 1'b0;
        else        access_q <= access;
    end

    // A new access is the inactive-to-active transition.
    always_comb access_start = access && !access_q;
endmodule

// File: rtl/pr_toggle.sv
// Toggle-bit state: inverts once per new access while the program period runs.
// Assumes: access_start is high for exactly one cycle per access.
module pr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic access_start,
    output logic tog_next
);
    logic tog_q;

    // Next toggle value, which the output register sees in the same cycle.
    always_comb tog_next = (busy && access_start) ? !tog_q : tog_q;

    // Hold the toggle state; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_next;
    end
endmodule

// File: rtl/pr_read_mux.sv
// Chooses the read source and registers the result.
// Assumes: DATA_W >= 3 so that the two status bits and a zero field all fit.
module pr_read_mux
    import poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              busy,
    input  logic              id_sel,
    input  logic              tog_next,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_data,
    input  logic [DATA_W-1:0] id_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    rd_src_e           src;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] data_next;

    // Pick the source for this cycle.
    always_comb begin
        if (!access)     src = SRC_OFF;
        else if (busy)   src = SRC_STATUS;
        else if (id_sel) src = SRC_IDENT;
        else             src = SRC_ARRAY;
    end

    // Build the status word: inverted poll bit, toggle bit, zeros below.
    always_comb begin
        status_word           = '0;
        status_word[POLL_BIT] = !last_byte[POLL_BIT];
        status_word[TOG_BIT]  = tog_next;
    end

    // Read data multiplexer.
    always_comb begin
        case (src)
            SRC_STATUS: data_next = status_word;
            SRC_IDENT:  data_next = id_data;
            SRC_ARRAY:  data_next = array_data;
            default:    data_next = '0;
        endcase
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (src != SRC_OFF);
            rd_data  <= data_next;
        end
    end
endmodule

// File: rtl/poll_read_path.sv
// Top of the polling read path: access decode, toggle state and data mux.
// Assumes: all inputs are synchronous to clk; busy covers the whole program period.
module poll_read_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_data,
    input  logic              id_sel,
    input  logic [DATA_W-1:0] id_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic access;
    logic access_start;
    logic tog_next;

    pr_select_edge u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .access       (access),
        .access_start (access_start)
    );

    pr_toggle u_tog (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .access_start (access_start),
        .tog_next     (tog_next)
    );

    pr_read_mux #(.DATA_W(DATA_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .access     (access),
        .busy       (busy),
        .id_sel     (id_sel),
        .tog_next   (tog_next),
        .last_byte  (last_byte),
        .array_data (array_data),
        .id_data    (id_data),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/poll_read_path_chk.sv
// Checker for the polling read path, watching its ports only.
// Assumes: inputs change only between clock edges.
module poll_read_path_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic [DATA_W-1:0] last_byte,
    input logic [DATA_W-1:0] array_data,
    input logic              id_sel,
    input logic [DATA_W-1:0] id_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    logic acc;
    logic up_q;

    // Access condition as seen at the ports.
    always_comb acc = !cs_n && !oe_n && we_n;

    // Marks cycles at least one clock after reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!rd_valid && rd_data == '0)); // R2

    AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !busy && !id_sel) |=> (rd_valid && rd_data == $past(array_data))); // R3

    AST_IDLE_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !busy && id_sel) |=> (rd_data == $past(id_data))); // R4

    AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy) |=> (rd_data[DATA_W-1] == !$past(last_byte[DATA_W-1]))); // R5

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy) |=> (rd_data[DATA_W-3:0] == '0)); // R6

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && acc && $past(acc) && busy && $past(busy)) |=> $stable(rd_data[DATA_W-2])); // R7
endmodule

bind poll_read_path poll_read_path_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .busy       (busy),
    .last_byte  (last_byte),
    .array_data (array_data),
    .id_sel     (id_sel),
    .id_data    (id_data),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
);

// File: tb/poll_read_path_tb_top.sv
// Scoreboard bench: the driver queues expected results and the monitor compares them.
module poll_read_path_tb_top;
    localparam int DW = 8;

    typedef struct {
        int          due;
        logic        valid;
        logic [DW-1:0] data;
        string       tag;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cs_n = 1, oe_n = 1, we_n = 1, busy = 0, id_sel = 0;
    logic [DW-1:0] last_byte = '0, array_data = '0, id_data = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];

    // Bench model of the access edge and the toggle bit.
    logic m_act = 0;
    logic m_tog = 0;

    poll_read_path #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .last_byte(last_byte), .array_data(array_data),
        .id_sel(id_sel), .id_data(id_data), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Drive one cycle of inputs and queue the result expected one clock later.
    task automatic step(input logic c, input logic o, input logic w, input logic b,
                        input logic [DW-1:0] lb, input logic [DW-1:0] ad,
                        input logic is, input logic [DW-1:0] idd, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        cs_n = c; oe_n = o; we_n = w; busy = b;
        last_byte = lb; array_data = ad; id_sel = is; id_data = idd;
        acc = !c && !o && w;
        if (b && acc && !m_act) m_tog = !m_tog;
        m_act = acc;
        e.due = cyc + 1;
        e.tag = tag;
        e.valid = acc;
        if (!acc)    e.data = '0;
        else if (b)  e.data = {!lb[DW-1], m_tog, {(DW-2){1'b0}}};
        else if (is) e.data = idd;
        else         e.data = ad;
        sb.push_back(e);
    endtask

    // Idle gap: no access for one cycle.
    task automatic gap(input logic b, input string tag);
        step(1, 1, 1, b, 8'h00, 8'hFF, 0, 8'h00, tag);
    endtask

    // Monitor: compares queued items once their cycle has come.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rd_valid !== e.valid || rd_data !== e.data) begin
                errors++;
                $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
                         e.tag, rd_valid, rd_data, e.valid, e.data);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, observed during reset and in the first cycle after it
        cs_n = 0; oe_n = 0; we_n = 1;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== 0 || rd_data !== '0) begin
            errors++;
            $display("FAIL R1 in reset: got %0b/%02h, expected 0/00", rd_valid, rd_data);
        end
        rst_n = 1;
        cs_n = 1; oe_n = 1;
        @(negedge clk);
        checks++;
        if (rd_valid !== 0 || rd_data !== '0) begin
            errors++;
            $display("FAIL R1 after reset: got %0b/%02h, expected 0/00", rd_valid, rd_data);
        end

        // R3: idle array reads with several patterns
        step(0, 0, 1, 0, 8'h00, 8'hA5, 0, 8'h1F, "R3 array A5");
        step(0, 0, 1, 0, 8'h00, 8'h3C, 0, 8'h1F, "R3 array 3C");
        gap(0, "R2 gap");
        // R4: identification override, array value ignored
        step(0, 0, 1, 0, 8'h00, 8'h77, 1, 8'h1F, "R4 ident 1F");
        step(0, 0, 1, 0, 8'h00, 8'h00, 1, 8'hD5, "R4 ident D5");
        // R2: each disabling condition
        step(1, 0, 1, 0, 8'h00, 8'hAA, 0, 8'h00, "R2 cs high");
        step(0, 1, 1, 0, 8'h00, 8'hAA, 0, 8'h00, "R2 oe high");
        step(0, 0, 0, 0, 8'h00, 8'hAA, 0, 8'h00, "R2 we low");
        step(0, 0, 0, 1, 8'h80, 8'hAA, 0, 8'h00, "R2 we low busy");

        // R9: access already running when busy rises
        step(0, 0, 1, 0, 8'h80, 8'h5A, 0, 8'h00, "R9 pre-busy");
        step(0, 0, 1, 1, 8'h80, 8'h5A, 0, 8'h00, "R9 busy rises");
        step(0, 0, 1, 1, 8'h80, 8'h5A, 0, 8'h00, "R9 held");
        gap(1, "R2 busy gap");

        // R5 R6 R7: polling accesses of two cycles each, with different last bytes
        for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] lb;
            lb = (k % 2) ? 8'h7F : 8'h80;
            step(0, 0, 1, 1, lb, 8'hFF, k[0], 8'hFF, "R7 new access");
            step(0, 0, 1, 1, lb, 8'hFF, 0, 8'hFF, "R6 held access");
            if (k == 1) step(1, 0, 1, 1, lb, 8'hFF, 0, 8'hFF, "R7 cs release");
            else        step(0, 1, 1, 1, lb, 8'hFF, 0, 8'hFF, "R7 oe release");
        end
        // R5: released by both strobes at once
        step(0, 0, 1, 1, 8'h01, 8'hFF, 0, 8'h00, "R5 poll bit7 clear");
        step(1, 1, 1, 1, 8'h01, 8'hFF, 0, 8'h00, "R7 both release");
        step(0, 0, 1, 1, 8'hFE, 8'h00, 0, 8'h00, "R5 poll bit7 set");
        gap(1, "R2 gap");

        // R8: busy drops, true data returns and the toggle state stays put
        step(0, 0, 1, 0, 8'h00, 8'hC3, 0, 8'h00, "R8 true data");
        gap(0, "R8 gap");
        step(0, 0, 1, 0, 8'h00, 8'h41, 0, 8'h00, "R8 true data 2");
        gap(0, "R8 gap");
        step(0, 0, 1, 1, 8'h80, 8'h00, 0, 8'h00, "R8 toggle continues");
        gap(0, "R8 end");

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule